// File: doc/BRIEF.md
# Clocked Serial Command Receiver

This block takes bytes from a host over a clocked serial link and hands each finished byte to the rest of the chip. The link has five lines. A serial data line carries the bits and a serial clock line times them. Two chip selects of opposite polarity must both be active before anything is accepted. A data/command select line tells whether the byte is display data or an instruction. A mode input must sit at its serial setting for the receiver to run at all.

All link inputs are synchronised into the system clock domain, and the rising edges of the serial clock are detected there. Bits enter a shift register with the most significant bit first. A bit counter decides when eight bits have arrived. On the eighth edge the byte is presented together with its data/command flag, and a byte-valid pulse lasts exactly one system cycle. Deselecting the chip or asserting reset throws away any partial byte, so only complete eight-bit units are ever delivered.

Top module: `serCmdRx`

## Requirements
- R1: After reset, byteValid is 0, byteOut is 0x00 and isData is 0.
- R2: Serial bits are assembled most significant bit first. The first bit sent after selection lands in byteOut[7] and the eighth bit lands in byteOut[0].
- R3: A byte is delivered only on the eighth rising edge of sclk since selection or since the last byte. Seven edges produce no byteValid pulse.
- R4: Each completed byte produces exactly one byteValid pulse, and that pulse lasts one system clock cycle.
- R5: isData takes the level of dcSel sampled with the eighth bit. A value of 1 marks display data and a value of 0 marks an instruction.
- R6: The receiver is selected only while csLowN is 0 and csHigh is 1. With any other combination, sclk, sdata and dcSel are ignored and no byte is delivered.
- R7: Deselecting the receiver clears the bit counter and the shift register. After reselection, a full eight edges are needed for the next byte, and that byte holds only the new bits.
- R8: Asserting rstN low in the middle of a byte discards the partial byte. The next byte after reset needs a full eight edges.
- R9: While serialMode is 0, the serial clock is ignored and no byte is delivered.
- R10: byteOut and isData keep their values until the next completed byte, whatever sdata and dcSel do meanwhile.
- R11: Bytes sent back to back with no deselect between them are each delivered correctly, because the bit counter wraps after the eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialMode | input | 1 | 1 selects serial operation |
| csLowN | input | 1 | Chip select, active low |
| csHigh | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdata | input | 1 | Serial data |
| dcSel | input | 1 | 1 marks display data, 0 marks an instruction |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteOut | output | 8 | Last completed byte |
| isData | output | 1 | Data/command flag of the last byte |

## Verification
The assertions check on every cycle that the valid strobe never lasts two cycles and that the outputs change only on a capture. They also check that a deselect empties the shift register, that the flag follows the select sampled at capture, and that the counter advances by one on each edge. Only the bench scenarios can show the whole serial behaviour. These include the bit order, the count of exactly eight edges, how a partial byte is dropped after a deselect or a reset, and how wrong chip-select combinations or the parallel mode setting are ignored.

// File: rtl/serRxPkg.sv
package serRxPkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic clear;    // receiver not selected: empty the shift register
    logic shift;    // a qualified sclk rising edge
    logic capture;  // the shift that completes a unit
    logic bitIn;    // synchronised serial data bit
    logic dcIn;     // synchronised data/command select
  } rxStrobes_t;

endpackage

// File: rtl/serRxSync.sv
module serRxSync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= asyncIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/serRxCtrl.sv
module serRxCtrl
  import serRxPkg::*;
#(
  parameter int UNIT_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeS,
  input  logic       csLowNS,
  input  logic       csHighS,
  input  logic       sclkS,
  input  logic       sdataS,
  input  logic       dcS,
  output rxStrobes_t strobes
);

  localparam int CNT_W = $clog2(UNIT_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UNIT_BITS - 1);

  logic             enable;
  logic             sclkPrev;
  logic             rise;
  logic [CNT_W-1:0] bitCount;

  // Selected only when serial mode is set and both chip selects are active.
  assign enable = modeS & ~csLowNS & csHighS;
  assign rise   = enable & sclkS & ~sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCount <= '0;
    else if (!enable)         bitCount <= '0;
    else if (rise) begin
      if (bitCount == LAST)   bitCount <= '0;
      else                    bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strobes.clear   = ~enable;
    strobes.shift   = rise;
    strobes.capture = rise & (bitCount == LAST);
    strobes.bitIn   = sdataS;
    strobes.dcIn    = dcS;
  end

  // R11: the counter steps by one per qualified edge below the last bit.
  a_r11_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (rise && bitCount != LAST) |=> (bitCount == $past(bitCount) + 1'b1));

  // R11: the counter wraps to zero after the edge that completes a unit.
  a_r11_count_wraps: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (bitCount == '0));

endmodule

// File: rtl/serRxDatapath.sv
module serRxDatapath
  import serRxPkg::*;
#(
  parameter int UNIT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobes_t           strobes,
  output logic                 byteValid,
  output logic [UNIT_BITS-1:0] byteOut,
  output logic                 isData
);

  logic [UNIT_BITS-1:0] shiftReg;
  logic [UNIT_BITS-1:0] nextShift;

  assign nextShift = {shiftReg[UNIT_BITS-2:0], strobes.bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobes.clear) shiftReg <= '0;
    else if (strobes.shift) shiftReg <= nextShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      byteOut   <= '0;
      isData    <= 1'b0;
    end else begin
      byteValid <= strobes.capture;
      if (strobes.capture) begin
        byteOut <= nextShift;
        isData  <= strobes.dcIn;
      end
    end
  end

  a_r4_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(byteOut) && $stable(isData)));

  a_r7_clear_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (shiftReg == '0));

  a_r5_flag_from_select: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (isData == $past(strobes.dcIn)));

endmodule

// File: rtl/serCmdRx.sv
module serCmdRx
  import serRxPkg::*;
#(
  parameter int UNIT_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialMode,
  input  logic                 csLowN,
  input  logic                 csHigh,
  input  logic                 sclk,
  input  logic                 sdata,
  input  logic                 dcSel,
  output logic                 byteValid,
  output logic [UNIT_BITS-1:0] byteOut,
  output logic                 isData
);

  localparam int N_SYNC = 6;

  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] synIn;
  rxStrobes_t        strobes;

  assign rawIn = {serialMode, csLowN, csHigh, sclk, sdata, dcSel};

  serRxSync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (synIn)
  );

  serRxCtrl #(.UNIT_BITS(UNIT_BITS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeS   (synIn[5]),
    .csLowNS (synIn[4]),
    .csHighS (synIn[3]),
    .sclkS   (synIn[2]),
    .sdataS  (synIn[1]),
    .dcS     (synIn[0]),
    .strobes (strobes)
  );

  serRxDatapath #(.UNIT_BITS(UNIT_BITS)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .byteValid (byteValid),
    .byteOut   (byteOut),
    .isData    (isData)
  );

endmodule

// File: tb/sim_serCmdRx.sv
`timescale 1ns/1ps
module sim_serCmdRx;

  localparam int HALF  = 3;
  localparam int LIMIT = 150000;
  localparam int NVEC  = 6;
  // each entry: {dcSel, byte}
  localparam logic [8:0] VEC [NVEC] = '{9'h1A5, 9'h03C, 9'h1FF, 9'h000, 9'h180, 9'h001};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialMode = 1'b1;
  logic csLowN = 1'b1;
  logic csHigh = 1'b0;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic dcSel = 1'b0;
  logic byteValid;
  logic [7:0] byteOut;
  logic isData;

  int checkCount = 0;
  int failCount = 0;
  int pulseCount = 0;
  int validCycles = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serCmdRx u0 (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .csLowN(csLowN),
    .csHigh(csHigh), .sclk(sclk), .sdata(sdata), .dcSel(dcSel),
    .byteValid(byteValid), .byteOut(byteOut), .isData(isData)
  );

  // Counts cycles with byteValid high and separate pulses.
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (byteValid) validCycles++;
    if (byteValid && !prevValid) pulseCount++;
    prevValid = byteValid;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT && !done) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount + 1, failCount);
      $finish;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBits(input int n, input logic [7:0] val, input logic dc);
    dcSel = dc;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      sdata = val[i];
      waitN(HALF);
      sclk = 1'b1;
      waitN(HALF);
    end
    @(negedge clk);
    sclk = 1'b0;
    waitN(6);
  endtask

  task automatic selectOn();
    @(negedge clk);
    csLowN = 1'b0;
    csHigh = 1'b1;
    waitN(4);
  endtask

  initial begin
    int p0;
    int v0;
    waitN(3);
    // R1: reset state
    check(byteValid == 0 && byteOut == 8'h00 && isData == 0, "R1 reset state",
          {byteValid, isData, byteOut}, 0);
    @(negedge clk);
    rstN = 1'b1;
    selectOn();

    // R2 R4 R5 R11: vector table sent back to back
    for (int k = 0; k < NVEC; k++) begin
      p0 = pulseCount;
      v0 = validCycles;
      sendBits(8, VEC[k][7:0], VEC[k][8]);
      check(byteOut == VEC[k][7:0], "R2 R11 byte value msb first", byteOut, VEC[k][7:0]);
      check(isData == VEC[k][8], "R5 data/command flag", isData, VEC[k][8]);
      check(pulseCount - p0 == 1 && validCycles - v0 == 1, "R4 single one-cycle pulse",
            validCycles - v0, 1);
    end

    // R10: wiggle data and select without clock edges
    @(negedge clk);
    sdata = ~sdata;
    dcSel = ~VEC[NVEC-1][8];
    waitN(8);
    check(byteOut == VEC[NVEC-1][7:0] && isData == VEC[NVEC-1][8], "R10 outputs held",
          {isData, byteOut}, VEC[NVEC-1]);

    // R3: seven edges give no byte
    p0 = pulseCount;
    sendBits(7, 8'hFE, 1'b1);
    check(pulseCount == p0, "R3 seven edges no byte", pulseCount - p0, 0);
    // R7: deselect drops the partial byte, next byte needs full eight edges
    @(negedge clk);
    csLowN = 1'b1;
    waitN(4);
    selectOn();
    p0 = pulseCount;
    sendBits(4, 8'hF0, 1'b1);
    check(pulseCount == p0, "R7 four edges after reselect no byte", pulseCount - p0, 0);
    @(negedge clk);
    csHigh = 1'b0;
    waitN(4);
    selectOn();
    sendBits(8, 8'h5A, 1'b0);
    check(pulseCount - p0 == 1 && byteOut == 8'h5A && isData == 0, "R7 clean byte after reselect",
          byteOut, 8'h5A);

    // R6: other chip-select combinations ignore the clock
    p0 = pulseCount;
    @(negedge clk); csLowN = 1'b1; csHigh = 1'b1; waitN(4);
    sendBits(8, 8'h33, 1'b1);
    check(pulseCount == p0 && byteOut == 8'h5A, "R6 csLowN high ignored", byteOut, 8'h5A);
    @(negedge clk); csLowN = 1'b0; csHigh = 1'b0; waitN(4);
    sendBits(8, 8'h33, 1'b1);
    check(pulseCount == p0 && byteOut == 8'h5A, "R6 csHigh low ignored", byteOut, 8'h5A);
    @(negedge clk); csLowN = 1'b1; csHigh = 1'b0; waitN(4);
    sendBits(8, 8'h33, 1'b1);
    check(pulseCount == p0 && isData == 0, "R6 both inactive ignored", isData, 0);

    // R9: parallel mode ignores the serial clock
    selectOn();
    @(negedge clk); serialMode = 1'b0; waitN(4);
    sendBits(8, 8'hC3, 1'b1);
    check(pulseCount == p0 && byteOut == 8'h5A, "R9 parallel mode ignored", byteOut, 8'h5A);
    @(negedge clk); serialMode = 1'b1; waitN(4);
    sendBits(8, 8'hC3, 1'b1);
    check(pulseCount - p0 == 1 && byteOut == 8'hC3, "R9 serial mode restored", byteOut, 8'hC3);

    // R8: reset mid-byte
    sendBits(3, 8'hE0, 1'b1);
    @(negedge clk); rstN = 1'b0; waitN(3);
    check(byteOut == 8'h00 && isData == 0 && byteValid == 0, "R8 R1 outputs cleared by reset",
          byteOut, 0);
    @(negedge clk); rstN = 1'b1; waitN(4);
    p0 = pulseCount;
    sendBits(5, 8'h96, 1'b1);
    check(pulseCount == p0, "R8 partial count discarded", pulseCount - p0, 0);
    sendBits(3, 8'h60, 1'b1);
    check(pulseCount - p0 == 1 && byteOut == 8'h93 && isData == 1, "R8 full byte after reset",
          byteOut, 8'h93);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule